// File: doc/BRIEF.md
# Transfer-Record Clear Permission Checker

This block recognises the supervisor instruction that wipes the control-transfer history buffer. It decides whether that instruction may execute in the current privilege mode or must trap. Each cycle it takes a 32-bit instruction word and an issue strobe. It also takes the current privilege mode, two flags that say whether the machine-level and supervisor-level record features are built in, and the record-enable bits from the machine-level and hypervisor-level state-enable registers.

One cycle later it reports four things through registered outputs. It says whether the word was the clear instruction. It says whether the clear may go ahead, in which case a one-cycle strobe is sent to the record buffer. Otherwise it gives the kind of fault that should be raised: an illegal-instruction fault or a virtual-instruction fault.

The block only classifies. The pipeline around it delivers the trap and owns the state-enable registers.

Top module: `trc_clear_chk`

## Requirements
- R1: When `instr_valid` is 1 and `instr` equals 32'h1040_0073 exactly, `hit_q` is 1 in the following cycle.
- R2: When the issued word differs from 32'h1040_0073 in any bit, all four outputs are 0 in the following cycle.
- R3: When the machine-level record feature is absent (`m_ext_impl`=0), a matching instruction raises `illegal_q` in every mode.
- R4: In user mode (`priv_mode`=3'd2), a matching instruction always raises `illegal_q`.
- R5: In supervisor (3'd1), virtual-supervisor (3'd3) or virtual-user (3'd4) mode, a matching instruction raises `illegal_q` when `s_ext_impl`=0 or `m_state_en`=0.
- R6: If no illegal condition holds, `virtual_q` is raised in mode 3'd3 when `h_state_en`=0, and always in mode 3'd4.
- R7: Illegal takes priority over virtual, so `illegal_q` and `virtual_q` are never both 1.
- R8: `clear_q` is 1 exactly when a matching instruction raises no fault. In machine mode (3'd0) the clear proceeds whenever `m_ext_impl`=1, whatever `s_ext_impl`, `m_state_en` and `h_state_en` are.
- R9: `clear_q` is registered and lasts one cycle per issued instruction. All outputs are 0 while `rst` is high and in the cycle after it is released.
- R10: Mode codes 3'd5 to 3'd7 are treated as faulting, so a matching instruction in one of them raises `illegal_q`.
- R11: A cycle with `instr_valid`=0 produces all-zero outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is being issued this cycle |
| instr | input | 32 | Instruction word |
| priv_mode | input | 3 | Privilege mode: 0 M, 1 S, 2 U, 3 VS, 4 VU |
| m_ext_impl | input | 1 | Machine-level record feature is implemented |
| s_ext_impl | input | 1 | Supervisor-level record feature is implemented |
| m_state_en | input | 1 | Record-enable bit of the machine state-enable register |
| h_state_en | input | 1 | Record-enable bit of the hypervisor state-enable register |
| hit_q | output | 1 | The issued word was the clear instruction |
| clear_q | output | 1 | One-cycle clear strobe to the record buffer |
| illegal_q | output | 1 | Illegal-instruction fault |
| virtual_q | output | 1 | Virtual-instruction fault |

## Verification
Two conditions can hold in the same cycle: one that makes the instruction illegal and one that would make it a virtual-instruction fault. Virtual-supervisor mode with both state-enable bits at 0 produces this, and so does virtual-user mode with the supervisor feature missing. The bench judges these cases by requiring `illegal_q` alone, with `virtual_q` and `clear_q` low. A second check covers the other overlap, where a mode that needs the state-enable bits is replaced by machine mode with every optional input at 0. That case must still produce a clear.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned MODE_W = 3;
  localparam logic [INSN_W-1:0] CLR_PATTERN = 32'h1040_0073;

  typedef enum logic [MODE_W-1:0] {
    MODE_M  = 3'd0,
    MODE_S  = 3'd1,
    MODE_U  = 3'd2,
    MODE_VS = 3'd3,
    MODE_VU = 3'd4
  } trc_mode_e;

  typedef struct packed {
    logic hit;
    logic clr;
    logic ill;
    logic vi;
  } trc_res_t;

endpackage

// File: rtl/trc_decode.sv
module trc_decode #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] PATTERN = 32'h1040_0073,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic [W-1:0] word,
  output logic         is_match
);
  localparam int unsigned NCHUNK = (W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W  = NCHUNK * CHUNK_W;

  logic [PAD_W-1:0]  word_pad;
  logic [PAD_W-1:0]  pat_pad;
  logic [NCHUNK-1:0] chunk_eq;

  assign word_pad = PAD_W'(word);
  assign pat_pad  = PAD_W'(PATTERN);

  // Equality per slice; the slices are then reduced in one AND.
  for (genvar g = 0; g < NCHUNK; g++) begin : g_slice
    assign chunk_eq[g] =
      (word_pad[g*CHUNK_W +: CHUNK_W] == pat_pad[g*CHUNK_W +: CHUNK_W]);
  end

  assign is_match = &chunk_eq;
endmodule

// File: rtl/trc_classify.sv
module trc_classify
  import trc_pkg::*;
#(
  parameter int unsigned MW = MODE_W
) (
  input  logic [MW-1:0] mode,
  input  logic          m_impl,
  input  logic          s_impl,
  input  logic          m_en,
  input  logic          h_en,
  output logic          fault_ill,
  output logic          fault_vi,
  output logic          allow
);
  logic sup_blocked;

  assign sup_blocked = !s_impl || !m_en;

  always_comb begin
    fault_ill = 1'b0;
    fault_vi  = 1'b0;
    if (!m_impl) begin
      fault_ill = 1'b1;
    end else begin
      case (mode)
        MODE_M:  ;
        MODE_U:  fault_ill = 1'b1;
        MODE_S:  fault_ill = sup_blocked;
        MODE_VS: begin
          if (sup_blocked) fault_ill = 1'b1;
          else if (!h_en)  fault_vi  = 1'b1;
        end
        MODE_VU: begin
          if (sup_blocked) fault_ill = 1'b1;
          else             fault_vi  = 1'b1;
        end
        default: fault_ill = 1'b1;
      endcase
    end
  end

  assign allow = !fault_ill && !fault_vi;
endmodule

// File: rtl/trc_outreg.sv
module trc_outreg
  import trc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     issue,
  input  logic     hit,
  input  logic     allow,
  input  logic     f_ill,
  input  logic     f_vi,
  output trc_res_t res_q
);
  trc_res_t res_d;

  always_comb begin
    res_d     = '0;
    res_d.hit = issue && hit;
    res_d.clr = res_d.hit && allow;
    res_d.ill = res_d.hit && f_ill;
    res_d.vi  = res_d.hit && f_vi;
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_d;
  end

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
    !(res_q.ill && res_q.vi)); // R7
  AST_CLR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    res_q.clr |-> (res_q.hit && !res_q.ill && !res_q.vi)); // R8
  AST_QUIET_MISS: assert property (@(posedge clk) disable iff (rst)
    !res_q.hit |-> (!res_q.clr && !res_q.ill && !res_q.vi)); // R2
  AST_RST_LOW: assert property (@(posedge clk)
    rst |=> !res_q.clr); // R9
endmodule

// File: rtl/trc_clear_chk.sv
module trc_clear_chk
  import trc_pkg::*;
#(
  parameter int unsigned IW = INSN_W,
  parameter int unsigned MW = MODE_W,
  parameter logic [IW-1:0] PATTERN = CLR_PATTERN,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr,
  input  logic [MW-1:0] priv_mode,
  input  logic          m_ext_impl,
  input  logic          s_ext_impl,
  input  logic          m_state_en,
  input  logic          h_state_en,
  output logic          hit_q,
  output logic          clear_q,
  output logic          illegal_q,
  output logic          virtual_q
);
  logic     dec_hit;
  logic     f_ill, f_vi, allow;
  trc_res_t res_q;

  trc_decode #(.W(IW), .PATTERN(PATTERN), .CHUNK_W(CHUNK_W)) u_dec (
    .word(instr), .is_match(dec_hit)
  );

  trc_classify #(.MW(MW)) u_cls (
    .mode(priv_mode), .m_impl(m_ext_impl), .s_impl(s_ext_impl),
    .m_en(m_state_en), .h_en(h_state_en),
    .fault_ill(f_ill), .fault_vi(f_vi), .allow(allow)
  );

  trc_outreg u_out (
    .clk(clk), .rst(rst), .issue(instr_valid), .hit(dec_hit),
    .allow(allow), .f_ill(f_ill), .f_vi(f_vi), .res_q(res_q)
  );

  assign hit_q     = res_q.hit;
  assign clear_q   = res_q.clr;
  assign illegal_q = res_q.ill;
  assign virtual_q = res_q.vi;

  AST_HIT: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr == PATTERN) |=> hit_q); // R1
  AST_U_FAULT: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr == PATTERN && priv_mode == MODE_U) |=> illegal_q); // R4
  AST_NO_MEXT: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr == PATTERN && !m_ext_impl) |=> illegal_q); // R3
  AST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !hit_q); // R11
endmodule

// File: tb/trc_clear_chk_tb.sv
`timescale 1ns/1ps
module trc_clear_chk_tb_top;
  localparam logic [31:0] PAT = 32'h1040_0073;
  localparam int NV = 18;
  // {use_pat, valid, mode[2:0], m_impl, s_impl, m_en, h_en, exp hit, clr, ill, vi}
  localparam logic [12:0] VEC [NV] = '{
    13'b1_1_000_1111_1100, // R1 M, all on
    13'b1_1_000_1000_1100, // R8 M clears with optional inputs low
    13'b1_1_000_0111_1010, // R3 no machine feature
    13'b1_1_001_1110_1100, // R8 S allowed
    13'b1_1_001_1011_1010, // R5 S no supervisor feature
    13'b1_1_001_1101_1010, // R5 S machine enable low
    13'b1_1_010_1111_1010, // R4 U
    13'b1_1_011_1111_1100, // R8 VS allowed
    13'b1_1_011_1110_1001, // R6 VS hyp enable low
    13'b1_1_011_1100_1010, // R7 VS both enables low
    13'b1_1_100_1111_1001, // R6 VU
    13'b1_1_100_1011_1010, // R7 VU no supervisor feature
    13'b1_1_100_0111_1010, // R3 VU no machine feature
    13'b1_1_101_1111_1010, // R10 mode 5
    13'b1_1_111_1111_1010, // R10 mode 7
    13'b0_1_000_1111_0000, // R2 wrong word, M
    13'b0_1_010_1111_0000, // R2 wrong word, U
    13'b1_0_010_1111_0000  // R11 not issued
  };
  localparam int VREQ [NV] = '{1,8,3,8,5,5,4,8,6,7,6,7,3,10,10,2,2,11};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [2:0]  priv_mode = '0;
  logic        m_ext_impl = 1'b0, s_ext_impl = 1'b0, m_state_en = 1'b0, h_state_en = 1'b0;
  logic        hit_q, clear_q, illegal_q, virtual_q;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  trc_clear_chk dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .priv_mode(priv_mode), .m_ext_impl(m_ext_impl), .s_ext_impl(s_ext_impl),
    .m_state_en(m_state_en), .h_state_en(h_state_en),
    .hit_q(hit_q), .clear_q(clear_q), .illegal_q(illegal_q), .virtual_q(virtual_q)
  );

  task automatic check(input logic [3:0] exp, input int req, input string what);
    logic [3:0] got;
    got = {hit_q, clear_q, illegal_q, virtual_q};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // Drive on the falling edge, then sample 1 ns after the next rising edge.
  task automatic issue(input logic v, input logic [31:0] w, input logic [2:0] m,
                       input logic [3:0] fl);
    @(negedge clk);
    instr_valid = v; instr = w; priv_mode = m;
    {m_ext_impl, s_ext_impl, m_state_en, h_state_en} = fl;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9 reset state, with a matching word applied
    instr_valid = 1'b1; instr = PAT; m_ext_impl = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(4'b0000, 9, "outputs low during reset");
    @(negedge clk); rst = 1'b0;
    instr_valid = 1'b0;
    @(posedge clk); #1 check(4'b0000, 9, "first cycle after reset");

    for (int i = 0; i < NV; i++) begin
      logic [12:0] e;
      e = VEC[i];
      issue(e[11], e[12] ? PAT : (PAT ^ 32'h0000_1000), e[10:8], e[7:4]);
      check(e[3:0], VREQ[i], $sformatf("vector %0d", i));
    end

    // R2 every single-bit corruption of the word is ignored
    for (int b = 0; b < 32; b++) begin
      issue(1'b1, PAT ^ (32'h1 << b), 3'd0, 4'b1111);
      check(4'b0000, 2, $sformatf("bit %0d flipped", b));
    end
    issue(1'b1, 32'h0, 3'd0, 4'b1111);
    check(4'b0000, 2, "all-zero word");

    // R9 strobe lasts one cycle per issue
    issue(1'b1, PAT, 3'd0, 4'b1111);
    check(4'b1100, 9, "strobe high");
    issue(1'b0, PAT, 3'd0, 4'b1111);
    check(4'b0000, 9, "strobe drops");
    issue(1'b1, PAT, 3'd1, 4'b1110);
    issue(1'b1, PAT, 3'd1, 4'b1110);
    check(4'b1100, 1, "back-to-back issue");

    // R9 reset asserted with a permitted issue pending
    @(negedge clk); rst = 1'b1; instr_valid = 1'b1; instr = PAT; priv_mode = 3'd0;
    @(posedge clk); #1 check(4'b0000, 9, "reset beats clear");
    @(negedge clk); rst = 1'b0; instr_valid = 1'b0;
    @(posedge clk); #1 check(4'b0000, 9, "quiet after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule